// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM organised as 262,144 words of 4 bits. It turns one host request into a timed sequence on the three active-low memory strobes: chip select, write strobe and output enable. It also controls the drivers of the shared data bus and registers the word a read returns. The host presents an address, write data and a direction flag with a one-cycle request, and then waits for a one-cycle completion pulse. A read result stays on the host data output until the next read finishes.

Every strobe phase lasts a whole number of clock cycles. The block derives each count from a nanosecond minimum (given in picoseconds) and the clock period, rounding up, with a floor of one cycle. Writes keep output enable high for the whole write, which allows the shorter write-pulse minimum. The block drives the data bus only inside the write pulse, and only after output enable has been high for at least the turnaround count. As a result, the memory and the block never drive the bus in the same cycle. The data pads themselves live outside this block, which exposes separate drive-data, drive-enable and sampled-input pins.

Top module: `asram_seq`

## Requirements
- R1: During and after reset, and while idle, chip select, write strobe and output enable are all high (1) and the data drive enable is low (0).
- R2: A write holds chip select low and output enable high for the whole access. The write strobe is low for exactly WP cycles. Completion is reported max(SETUP,TURN)+WP+1 clock edges after the accepting edge.
- R3: The data drive enable is high exactly while the write strobe is low, and it rises only after output enable has been high for at least TURN cycles.
- R4: The memory address stays stable on every cycle in which chip select is low.
- R5: A read keeps the write strobe high and holds output enable low for exactly ACC cycles. It returns the word the memory presents at the end of that phase, and reports completion SETUP+ACC edges after the accepting edge.
- R6: The completion output is high for exactly one cycle per accepted request.
- R7: A request raised while an access is in progress is ignored and causes no memory access.
- R8: The drive enable is never high while output enable is low (no bus contention).
- R9: The host read data keeps its value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle request, taken only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 4 | Write data |
| host_rdata | output | 4 | Registered read data |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Data toward the memory |
| mem_dq_drive | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | 4 | Data sampled from the memory bus |

## Verification
The bench keeps the 8 ns clock but sets the timing minimums to 0, 12, 20 and 30 ns. The setup, turnaround, write-pulse and access phases then last 1, 2, 3 and 4 cycles. With multi-cycle phases the bench can observe the phase timer counting down, the write preamble taking the longer of setup and turnaround, and the strobe run lengths. With the default values every phase would be a single cycle and these effects would stay hidden. Random reads and writes over a narrow address window produce frequent read-after-write hits, and directed cases cover the extreme addresses, requests raised while busy, and reset in the middle of a write.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WPULSE,
        ST_WREC,
        ST_RACC
    } seq_state_e;

    // Whole clock cycles covering a minimum time, never below one.
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

    a_r2_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (capture) rdata_d = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata_q));
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 4,
    parameter int CNT_W       = 8,
    parameter int CLK_PS      = 8000,
    parameter int T_SETUP_PS  = 0,
    parameter int T_TURN_PS   = 4000,
    parameter int T_WP_PS     = 7000,
    parameter int T_ACC_PS    = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int SETUP_CYC  = ps_to_cycles(T_SETUP_PS, CLK_PS);
    localparam int TURN_CYC   = ps_to_cycles(T_TURN_PS, CLK_PS);
    localparam int WP_CYC     = ps_to_cycles(T_WP_PS, CLK_PS);
    localparam int ACC_CYC    = ps_to_cycles(T_ACC_PS, CLK_PS);
    localparam int WR_ARM_CYC = (SETUP_CYC > TURN_CYC) ? SETUP_CYC : TURN_CYC;

    typedef struct packed {
        seq_state_e        state;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              done;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             cap_en;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (host_req) begin
                    nxt_d.state = ST_ARM;
                    nxt_d.is_wr = host_we;
                    nxt_d.addr  = host_addr;
                    nxt_d.wdata = host_wdata;
                    tmr_load    = 1'b1;
                    tmr_val     = host_we ? CNT_W'(WR_ARM_CYC) : CNT_W'(SETUP_CYC);
                end
            end
            ST_ARM: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (cur_q.is_wr) begin
                        nxt_d.state = ST_WPULSE;
                        tmr_val     = CNT_W'(WP_CYC);
                    end else begin
                        nxt_d.state = ST_RACC;
                        tmr_val     = CNT_W'(ACC_CYC);
                    end
                end
            end
            ST_WPULSE: begin
                if (tmr_last) nxt_d.state = ST_WREC;
            end
            ST_WREC: begin
                nxt_d.state = ST_IDLE;
                nxt_d.done  = 1'b1;
            end
            ST_RACC: begin
                if (tmr_last) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.done  = 1'b1;
                    cap_en      = 1'b1;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        // Strobes are registered from the next state so they never glitch.
        nxt_d.ce_n = (nxt_d.state == ST_IDLE);
        nxt_d.we_n = (nxt_d.state != ST_WPULSE);
        nxt_d.oe_n = (nxt_d.state != ST_RACC);
        nxt_d.drv  = (nxt_d.state == ST_WPULSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
            cur_q.ce_n  <= 1'b1;
            cur_q.we_n  <= 1'b1;
            cur_q.oe_n  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    asram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) capture_i (
        .clk   (clk),
        .rst_n (rst_n),
        .capture (cap_en),
        .dq_in (mem_dq_in),
        .rdata (host_rdata)
    );

    assign host_done    = cur_q.done;
    assign mem_addr     = cur_q.addr;
    assign mem_ce_n     = cur_q.ce_n;
    assign mem_we_n     = cur_q.we_n;
    assign mem_oe_n     = cur_q.oe_n;
    assign mem_dq_out   = cur_q.wdata;
    assign mem_dq_drive = cur_q.drv;

    // Cycles output enable has been high, saturating; feeds the turnaround check.
    logic [CNT_W-1:0] oe_hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             oe_hi_q <= '0;
        else if (!mem_oe_n)     oe_hi_q <= '0;
        else if (oe_hi_q != '1) oe_hi_q <= oe_hi_q + CNT_W'(1);
    end

    a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive));
    a_r2_write_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));
    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_drive) |-> (oe_hi_q >= CNT_W'(TURN_CYC)));
    a_r3_drive_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive == !mem_we_n);
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive |-> mem_oe_n);
    a_r5_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));
endmodule

// File: tb/asram_seq_tb_top.sv
module asram_seq_tb_top;
    localparam int AW = 18;
    localparam int DW = 4;
    localparam int WR_LAT = 6;   // max(1,2) + 3 + 1
    localparam int RD_LAT = 5;   // 1 + 4
    localparam int WP_N   = 3;
    localparam int ACC_N  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic host_done;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 'z;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [DW-1:0] mem_arr [int];
    logic [DW-1:0] shadow [int];

    always #4 clk = ~clk;

    asram_seq #(
        .CLK_PS(8000), .T_SETUP_PS(0), .T_TURN_PS(12000),
        .T_WP_PS(20000), .T_ACC_PS(30000)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [DW-1:0] mem_rd(input int a);
        return mem_arr.exists(a) ? mem_arr[a] : '0;
    endfunction
    function automatic logic [DW-1:0] exp_rd(input int a);
        return shadow.exists(a) ? shadow[a] : '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model and protocol monitor, evaluated between edges.
    int we_run = 0, oe_run = 0;
    logic [AW-1:0] addr_at_sel;
    logic prev_ce_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && !mem_we_n && mem_dq_drive) mem_arr[int'(mem_addr)] = mem_dq_out;
            mem_dq_in <= (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem_rd(int'(mem_addr)) : 'z;
            if (mem_dq_drive && !mem_oe_n) check("R8 drive during oe low", 1, 0);
            if (mem_dq_drive != !mem_we_n) check("R3 drive follows we", mem_dq_drive, !mem_we_n);
            if (!mem_we_n && (!mem_oe_n || mem_ce_n)) check("R2 oe/ce during write", {mem_oe_n, mem_ce_n}, 2'b10);
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin check("R2 write pulse length", we_run, WP_N); we_run = 0; end
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin check("R5 access length", oe_run, ACC_N); oe_run = 0; end
            if (!mem_ce_n && prev_ce_n) addr_at_sel = mem_addr;
            else if (!mem_ce_n && mem_addr !== addr_at_sel) check("R4 address stable", mem_addr, addr_at_sel);
            prev_ce_n = mem_ce_n;
        end else begin
            we_run = 0; oe_run = 0; prev_ce_n = 1'b1;
        end
    end

    task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        lat = 0;
        while (!host_done && lat < 50) begin @(negedge clk); lat++; end
        if (we) shadow[int'(a)] = d;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        do_op(1'b1, a, d, lat);
        check("R2 write latency", lat, WR_LAT);
        @(negedge clk);
        check("R6 done single cycle", host_done, 0);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        int lat;
        do_op(1'b0, a, '0, lat);
        check("R5 read latency", lat, RD_LAT);
        check("R5 read data", host_rdata, exp_rd(int'(a)));
        @(negedge clk);
        check("R6 done single cycle", host_done, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [DW-1:0] held;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check("R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}, 4'b1110);
        check("R1 done low", host_done, 0);

        // Directed: extreme addresses, unwritten read.
        rd(18'h3FFFF);
        wr(18'h00000, 4'hA);
        wr(18'h3FFFF, 4'h5);
        rd(18'h00000);
        rd(18'h3FFFF);
        // Read right after read and write right after read (turnaround path).
        wr(18'h00010, 4'hC);
        rd(18'h00010);
        held = host_rdata;
        wr(18'h00011, 4'h3);
        check("R9 rdata held across write", host_rdata, held);

        // R7: second request while busy must be ignored.
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 18'h00020; host_wdata = 4'h9;
        @(negedge clk);
        host_addr = 18'h00021; host_wdata = 4'h6;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_done && lat < 50) begin @(negedge clk); lat++; end
        shadow[32'h20] = 4'h9;
        check("R7 busy request ignored, latency", lat, WR_LAT);
        repeat (3) @(negedge clk);
        check("R7 no second access", {mem_ce_n, mem_dq_drive}, 2'b10);
        rd(18'h00021);
        rd(18'h00020);

        // Random mix over a narrow window for read-after-write hits.
        for (int i = 0; i < 80; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) wr(a, DW'($urandom_range(0, 15)));
            else rd(a);
        end

        // R1: reset in the middle of a write pulse.
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 18'h00005; host_wdata = 4'hF;
        @(negedge clk);
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset mid-write", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}, 4'b1110);
        @(negedge clk);
        rst_n = 1'b1;
        if (mem_arr.exists(5)) shadow[5] = mem_arr[5];
        @(negedge clk);
        rd(18'h00005);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule